// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable, cycle-level model of a pipelined synchronous burst SRAM. The memory array is small and set by parameters. An access starts when one of two active-low address strobes captures the external address: a processor strobe or a controller strobe. Three chip enables, sampled only when an address is captured, decide whether the device is selected for that access. A 2-bit counter then walks the low two address bits through a linear burst each time the advance input is low.

Writes are lane-based. A global write stores every lane. Otherwise a byte write stores only the lanes whose select is low. Reads are registered, so the word appears on the bidirectional data bus after the edge that presented its address. The bus drives only while the asynchronous output enable is low and the last edge performed a read. A sleep input freezes the interface and keeps the stored contents.

Top module: `sbsram_core`

## Requirements
- R1: When either strobe is recognised, the edge captures `addr`, and the low two address bits seed the burst counter.
- R2: When both strobes are low and `sel1_n` is low, the processor strobe wins. A processor-started access is always a read, even with write controls asserted.
- R3: While `sel1_n` is high, the processor strobe is ignored. A low controller strobe then loads and deselects. With the controller strobe high, the current burst simply continues.
- R4: `sel1_n` (active low), `sel2` (active high) and `sel3_n` (active low) matter only on an address load. Changing them during a burst has no effect.
- R5: In a selected burst, `adv_n` low at an edge advances the counter by one, linearly modulo 4, with no carry into bit 2 and above. With `adv_n` high the same word is accessed again.
- R6: `wr_all_n` low writes every lane, regardless of `wr_byte_n` and `lane_sel_n`.
- R7: With `wr_all_n` high and `wr_byte_n` low, lane i (bits i*LANE_W upward) is written only when `lane_sel_n[i]` is low. With both write controls high, the access is a read.
- R8: Read data for the address accessed at an edge appears on `dq` after that same edge and is held until the next edge.
- R9: `out_en_n` acts asynchronously: when it is high, `dq` is high impedance within the same clock phase.
- R10: `dq` is high impedance after a deselected access or a write. On the first read after a deselected state, nothing drives before that read's data edge, even with `out_en_n` low.
- R11: With `sleep` high, strobes, writes and advance are ignored, `dq` goes high impedance, the device becomes deselected and stored data is kept.
- R12: After reset the device is deselected and `dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | External word address |
| proc_stb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| sel1_n | input | 1 | Chip enable 1, active low |
| sel2 | input | 1 | Chip enable 2, active high |
| sel3_n | input | 1 | Chip enable 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-activity state, active high |
| dq | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The bench targets the burst wrap from a start offset of 1 or more. A counter that carried into bit 2 would read a word from the next group of four. Both strobes low with a global write asserted checks the priority rule: a design that let the controller win would overwrite memory. The bench also changes the chip enables in the middle of a burst, and asserts the processor strobe while chip enable 1 is high. A design that re-sampled the enables or obeyed the gated strobe would go high impedance or jump address. It also probes high impedance after deselect, during sleep and when the output enable rises mid-cycle. In those cases a design with a stale valid flag would drive old data.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   localparam int BURST_BITS = 2;

endpackage

// File: rtl/sbsram_addr_seq.sv
module sbsram_addr_seq
   import sbsram_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic [ADDR_W-1:0] addr,
   input  logic              proc_stb_n,
   input  logic              ctrl_stb_n,
   input  logic              sel1_n,
   input  logic              sel2,
   input  logic              sel3_n,
   input  logic              adv_n,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              acc_sel,
   output logic              wr_ok
);

   localparam int HI_W = ADDR_W - BURST_BITS;

   logic [HI_W-1:0]       hi_q;
   logic [BURST_BITS-1:0] cnt_q;
   logic [BURST_BITS-1:0] cnt_inc;
   logic                  sel_q;
   logic                  take_p;
   logic                  take_c;
   logic                  load;
   logic                  enables_ok;
   logic                  step;

   always_comb begin
      take_p     = !proc_stb_n && !sel1_n;
      take_c     = !ctrl_stb_n && !take_p;
      load       = !sleep && (take_p || take_c);
      enables_ok = !sel1_n && sel2 && !sel3_n;
      step       = !sleep && !load && sel_q && !adv_n;
      cnt_inc    = cnt_q + 1'b1;
      if (load) begin
         acc_addr = addr;
         acc_sel  = enables_ok;
      end else begin
         acc_addr = {hi_q, (step ? cnt_inc : cnt_q)};
         acc_sel  = !sleep && sel_q;
      end
      wr_ok = !(load && take_p);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         cnt_q <= '0;
         sel_q <= 1'b0;
      end else if (sleep) begin
         sel_q <= 1'b0;
      end else if (load) begin
         hi_q  <= addr[ADDR_W-1:BURST_BITS];
         cnt_q <= addr[BURST_BITS-1:0];
         sel_q <= enables_ok;
      end else if (step) begin
         cnt_q <= cnt_inc;
      end
   end

endmodule

// File: rtl/sbsram_lane_ctl.sv
module sbsram_lane_ctl #(
   parameter int LANES = 4
) (
   input  logic             wr_ok,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] lane_we
);

   always_comb begin
      if (!wr_ok)
         lane_we = '0;
      else if (!wr_all_n)
         lane_we = '1;
      else if (!wr_byte_n)
         lane_we = ~lane_sel_n;
      else
         lane_we = '0;
   end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        lane_we,
   input  logic                    rd_en,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g])
            cells[addr] <= wdata[g*LANE_W +: LANE_W];
         if (rd_en)
            rdata[g*LANE_W +: LANE_W] <= cells[addr];
      end
   end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
   import sbsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    proc_stb_n,
   input  logic                    ctrl_stb_n,
   input  logic                    sel1_n,
   input  logic                    sel2,
   input  logic                    sel3_n,
   input  logic                    adv_n,
   input  logic                    wr_all_n,
   input  logic                    wr_byte_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    out_en_n,
   input  logic                    sleep,
   inout  wire  [LANES*LANE_W-1:0] dq
);

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < BURST_BITS + 1) begin : g_bad_aw
      $error("sbsram_core: ADDR_W must exceed the burst counter width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("sbsram_core: LANES and LANE_W must be positive");
   end

   logic [ADDR_W-1:0] acc_addr;
   logic              acc_sel;
   logic              wr_ok;
   logic [LANES-1:0]  lane_we;
   acc_kind_e         kind;
   logic              rd_vld_q;
   logic [DATA_W-1:0] rd_word;
   logic              dq_drv;

   sbsram_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep      (sleep),
      .addr       (addr),
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .sel1_n     (sel1_n),
      .sel2       (sel2),
      .sel3_n     (sel3_n),
      .adv_n      (adv_n),
      .acc_addr   (acc_addr),
      .acc_sel    (acc_sel),
      .wr_ok      (wr_ok)
   );

   sbsram_lane_ctl #(.LANES(LANES)) u_lane (
      .wr_ok      (wr_ok && acc_sel),
      .wr_all_n   (wr_all_n),
      .wr_byte_n  (wr_byte_n),
      .lane_sel_n (lane_sel_n),
      .lane_we    (lane_we)
   );

   always_comb begin
      if (!acc_sel)
         kind = ACC_NONE;
      else if (|lane_we)
         kind = ACC_WRITE;
      else
         kind = ACC_READ;
   end

   sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk     (clk),
      .addr    (acc_addr),
      .lane_we (lane_we),
      .rd_en   (kind == ACC_READ),
      .wdata   (dq),
      .rdata   (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_vld_q <= 1'b0;
      else
         rd_vld_q <= (kind == ACC_READ);
   end

   assign dq_drv = !out_en_n && rd_vld_q;
   assign dq     = dq_drv ? rd_word : {DATA_W{1'bz}};

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
   parameter int LANES  = 4,
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              proc_stb_n,
   input logic              ctrl_stb_n,
   input logic              sel1_n,
   input logic              sel2,
   input logic              sel3_n,
   input logic              adv_n,
   input logic              wr_all_n,
   input logic              wr_byte_n,
   input logic [LANES-1:0]  lane_sel_n,
   input logic              sleep,
   input logic              rd_vld_q,
   input logic [DATA_W-1:0] rd_word
);

   // R11
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !rd_vld_q);

   // R10
   desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !ctrl_stb_n && (proc_stb_n || sel1_n) && (sel1_n || !sel2 || sel3_n))
      |=> !rd_vld_q);

   // R2
   proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !proc_stb_n && !sel1_n && sel2 && !sel3_n) |=> rd_vld_q);

   // R7
   byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !ctrl_stb_n && proc_stb_n && !sel1_n && sel2 && !sel3_n &&
       !wr_byte_n && (lane_sel_n != '1)) |=> !rd_vld_q);

   // R5
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld_q && !sleep && proc_stb_n && ctrl_stb_n && adv_n && wr_all_n && wr_byte_n)
      |=> (rd_vld_q && $stable(rd_word)));

   // R4
   burst_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld_q && !sleep && proc_stb_n && ctrl_stb_n && wr_all_n && wr_byte_n)
      |=> rd_vld_q);

endmodule

bind sbsram_core sbsram_chk #(.LANES(LANES), .DATA_W(LANES*LANE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .proc_stb_n (proc_stb_n),
   .ctrl_stb_n (ctrl_stb_n),
   .sel1_n     (sel1_n),
   .sel2       (sel2),
   .sel3_n     (sel3_n),
   .adv_n      (adv_n),
   .wr_all_n   (wr_all_n),
   .wr_byte_n  (wr_byte_n),
   .lane_sel_n (lane_sel_n),
   .sleep      (sleep),
   .rd_vld_q   (rd_vld_q),
   .rd_word    (rd_word)
);

// File: tb/sbsram_core_tb.sv
`timescale 1ns/100ps
module sbsram_core_tb;

   localparam int AW    = 6;
   localparam int NB    = 4;
   localparam int LW    = 9;
   localparam int DW    = NB * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1;
   logic          sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
   logic          adv_n = 1'b1, wr_all_n = 1'b1, wr_byte_n = 1'b1;
   logic [NB-1:0] lane_sel_n = '1;
   logic          out_en_n = 1'b0, sleep = 1'b0;
   logic          tb_oe = 1'b0;
   logic [DW-1:0] tb_dout = '0;
   wire  [DW-1:0] dq;

   assign dq = tb_oe ? tb_dout : {DW{1'bz}};
   for (genvar g = 0; g < DW; g++) begin : g_pu
      pullup (dq[g]);
   end

   always #2 clk = ~clk;

   sbsram_core #(.ADDR_W(AW), .LANES(NB), .LANE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
      .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .adv_n(adv_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
      .out_en_n(out_en_n), .sleep(sleep), .dq(dq)
   );

   // reference model state
   logic [DW-1:0] ref_mem [DEPTH];
   int            m_hi, m_cnt;
   bit            m_sel, m_valid;
   logic [DW-1:0] m_data;
   int            checks = 0, errors = 0;
   bit            done = 0;

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      logic [DW-1:0] w;
      for (int l = 0; l < NB; l++)
         w[l*LW +: LW] = LW'((a * 13 + l * 5 + salt) % 500);
      return w;
   endfunction

   task automatic model_edge();
      bit p_rec, c_rec, act, wr_allowed;
      int a;
      logic [NB-1:0] msk;
      if (sleep) begin
         m_sel = 0; m_valid = 0;
         return;
      end
      p_rec = !proc_stb_n && !sel1_n;
      c_rec = !ctrl_stb_n && !p_rec;
      if (p_rec || c_rec) begin
         act   = !sel1_n && sel2 && !sel3_n;
         m_hi  = int'(addr) / 4;
         m_cnt = int'(addr) % 4;
         m_sel = act;
         wr_allowed = c_rec;
      end else begin
         act = m_sel;
         if (act && !adv_n) m_cnt = (m_cnt + 1) % 4;
         wr_allowed = 1;
      end
      a = m_hi * 4 + m_cnt;
      msk = '0;
      if (wr_allowed) begin
         if (!wr_all_n) msk = '1;
         else if (!wr_byte_n) msk = ~lane_sel_n;
      end
      if (act && msk != '0) begin
         for (int l = 0; l < NB; l++)
            if (msk[l]) ref_mem[a][l*LW +: LW] = tb_dout[l*LW +: LW];
         m_valid = 0;
      end else if (act) begin
         m_data = ref_mem[a]; m_valid = 1;
      end else begin
         m_valid = 0;
      end
   endtask

   task automatic check_bus(input string tag);
      logic [DW-1:0] exp;
      if (tb_oe) return;
      exp = (!out_en_n && m_valid) ? m_data : {DW{1'b1}};
      checks++;
      if (dq !== exp) begin
         errors++;
         $display("FAIL %s: dq=%h expected=%h at %0t", tag, dq, exp, $time);
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_bus(tag);
   endtask

   task automatic quiet();
      proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1; wr_all_n = 1; wr_byte_n = 1;
      lane_sel_n = '1; tb_oe = 0; out_en_n = 0; sleep = 0;
      sel1_n = 0; sel2 = 1; sel3_n = 0;
   endtask

   task automatic wr_burst4(input int base, input int salt);
      quiet(); out_en_n = 1; tb_oe = 1; wr_all_n = 0;
      ctrl_stb_n = 0; addr = AW'(base); tb_dout = pat(base, salt);
      step("R6");
      ctrl_stb_n = 1; adv_n = 0;
      for (int k = 1; k < 4; k++) begin
         tb_dout = pat((base & ~3) + ((base + k) & 3), salt);
         step("R5");
      end
      quiet();
   endtask

   task automatic rd_burst(input int base, input int beats, input bit use_p, input string tag);
      quiet();
      if (use_p) proc_stb_n = 0; else ctrl_stb_n = 0;
      addr = AW'(base);
      step(tag);
      quiet(); adv_n = 0;
      for (int k = 1; k < beats; k++) step(tag);
      quiet();
   endtask

   initial begin
      quiet();
      repeat (2) @(negedge clk);
      rst_n = 1;
      m_sel = 0; m_valid = 0; m_hi = 0; m_cnt = 0; m_data = '0;
      check_bus("R12");
      step("R12");

      // fill every word with global-write bursts
      for (int b = 0; b < DEPTH; b += 4) wr_burst4(b, 1);

      // linear wrap from offset 1 and 3, then hold with advance high
      rd_burst(5, 4, 0, "R5");
      rd_burst(11, 4, 0, "R5");
      step("R5");
      step("R8");
      // processor-started reads
      rd_burst(20, 2, 1, "R1");
      rd_burst(33, 1, 1, "R8");
      quiet(); step("R8");

      // byte write lanes 1 and 3 at word 9
      quiet(); out_en_n = 1; tb_oe = 1; wr_byte_n = 0; lane_sel_n = 4'b0101;
      ctrl_stb_n = 0; addr = 9; tb_dout = pat(9, 77);
      step("R7");
      rd_burst(9, 1, 0, "R7");
      // byte enable high and global write high: a read, nothing stored
      quiet(); ctrl_stb_n = 0; addr = 9; lane_sel_n = '0; tb_oe = 1; out_en_n = 1;
      tb_dout = pat(9, 200);
      step("R7");
      rd_burst(9, 1, 0, "R7");

      // global write ignores lane selects and byte enable
      quiet(); out_en_n = 1; tb_oe = 1; wr_all_n = 0; lane_sel_n = '1;
      ctrl_stb_n = 0; addr = 14; tb_dout = pat(14, 300);
      step("R6");
      rd_burst(14, 1, 0, "R6");

      // both strobes low with global write: processor wins, read only
      quiet(); proc_stb_n = 0; ctrl_stb_n = 0; wr_all_n = 0; addr = 22;
      tb_dout = pat(22, 400); tb_oe = 1; out_en_n = 1;
      step("R2");
      rd_burst(22, 1, 0, "R2");

      // processor strobe gated by sel1_n high: burst continues
      rd_burst(40, 2, 0, "R3");
      quiet(); sel1_n = 1; proc_stb_n = 0; addr = 3; adv_n = 0;
      step("R3");
      quiet(); sel1_n = 1; proc_stb_n = 0; ctrl_stb_n = 0; addr = 3;
      step("R3");
      quiet(); step("R3");

      // enables changed mid-burst are ignored
      rd_burst(48, 1, 0, "R4");
      quiet(); sel2 = 0; sel3_n = 1; adv_n = 0;
      step("R4"); step("R4");
      quiet(); ctrl_stb_n = 0; sel3_n = 1; addr = 50;
      step("R4");
      quiet(); step("R10");
      rd_burst(52, 2, 0, "R10");
      step("R10");

      // asynchronous output enable
      rd_burst(60, 1, 0, "R9");
      #0.5 out_en_n = 1;
      #0.5 check_bus("R9");
      out_en_n = 0;
      #0.5 check_bus("R9");
      step("R9");

      // sleep: write attempt ignored, bus quiet, data retained
      quiet(); sleep = 1; ctrl_stb_n = 0; wr_all_n = 0; addr = 61;
      tb_dout = pat(61, 500); tb_oe = 1;
      step("R11");
      quiet(); sleep = 1; step("R11");
      quiet(); adv_n = 0; step("R11");
      rd_burst(61, 1, 0, "R11");
      step("R11");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4.0 * 20000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule